// File: doc/BRIEF.md
# PWM Prescaler Clock-Enable Generator

This block turns one master clock into a family of slower tick rates for a multi-channel PWM unit. The rates are one-cycle enable pulses, not derived clocks, so every consumer stays in the master clock domain. A free-running binary prescaler provides eleven tap rates, the master rate divided by 2^k for k = 0 to 10. Two programmable linear dividers, A and B, each take one tap and divide it again by an 8-bit ratio. Each channel then picks any one of the thirteen resulting rates.

A global enable gates the whole block. While it is low the prescaler counter is cleared and both dividers drop to their `DIV_OFF` state. When the enable rises, the prescaler state machine moves from `PS_HOLD` to `PS_COUNT`. A divider moves from `DIV_OFF` to `DIV_RUN` once it is enabled with a valid configuration, meaning a nonzero ratio and a source select of 0 to 10. It returns to `DIV_OFF` when the enable drops or the configuration becomes invalid. While in `DIV_RUN`, any change to the divider's source or ratio clears its count and suppresses its output for that cycle. The configuration inputs behave like register fields and may change at any time.

Top module: `pwm_rate_gen`

## Requirements
- R1: With `blk_en` low, every output (`tap_tick`, `rate_a_tick`, `rate_b_tick`, `ch_tick`) is low. The same holds just after the synchronous reset, which is active-low on `rst_n`.
- R2: Let i be the number of rising edges since `blk_en` went high. Tap k (bit k of `tap_tick`) is high in the cycles where i mod 2^k = 2^k−1. Tap 0 is therefore high in every enabled cycle, and the prescaler counter wraps at 1024.
- R3: A running divider counts the ticks of the tap chosen by its 4-bit source field. It pulses for one cycle, in the same cycle as the tap tick, on every ratio-th tick. Ticks in the first enabled cycle are not counted.
- R4: A divider whose 8-bit ratio field is 0 never pulses.
- R5: A divider whose source field is 11 to 15 never pulses.
- R6: In a cycle where a divider's source or ratio differs from the previous cycle, that divider does not pulse and its count restarts. Its first pulse then comes on the ratio-th tap tick after that cycle.
- R7: Dividers A and B run independently: reconfiguring one does not change the pulse train of the other.
- R8: Each channel has a 4-bit field in `ch_sel` (channel c uses bits 4c+3:4c). Values 0 to 10 select tap k, 11 selects `rate_a_tick`, 12 selects `rate_b_tick`, and 13 to 15 give a constant low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | synchronous reset, active low |
| blk_en | input | 1 | global enable for all rates |
| div_a_src | input | 4 | tap select for divider A |
| div_a_ratio | input | 8 | divide ratio for divider A (0 = off) |
| div_b_src | input | 4 | tap select for divider B |
| div_b_ratio | input | 8 | divide ratio for divider B (0 = off) |
| ch_sel | input | 16 | four 4-bit per-channel rate selects |
| tap_tick | output | 11 | prescaler tap enables, bit k = divide by 2^k |
| rate_a_tick | output | 1 | divider A enable pulse |
| rate_b_tick | output | 1 | divider B enable pulse |
| ch_tick | output | 4 | per-channel selected enable |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- all outputs stay silent while disabled;
- tap 0 is high while enabled, and the taps nest, so tap k implies tap k−1;
- tap 1 alternates;
- a divider pulses only together with its selected tap, and never when its ratio is zero, its source is reserved, or its configuration changed that cycle;
- each channel equals the rate its select names.

Only the bench scenarios can show the exact pulse counts over long windows. These cover the divide-by-2^k spacing up to tap 10, the ratio-th-tick cadence of each divider, and the precise cycle of the first pulse after a reconfiguration.

// File: rtl/pwm_rate_pkg.sv
package pwm_rate_pkg;

    // State of the binary prescaler.
    typedef enum logic {
        PS_HOLD,   // disabled, counter held at zero
        PS_COUNT   // enabled, counter advancing
    } ps_state_e;

    // State of one linear divider.
    typedef enum logic {
        DIV_OFF,   // disabled or invalid configuration
        DIV_RUN    // counting source ticks
    } div_state_e;

endpackage

// File: rtl/pwm_tap_prescaler.sv
module pwm_tap_prescaler
    import pwm_rate_pkg::*;
#(
    parameter int TAP_COUNT = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 blk_en,
    output logic [TAP_COUNT-1:0] tap_tick
);

    localparam int CNT_W = TAP_COUNT - 1;

    ps_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // Next state and counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_HOLD: begin
                if (blk_en) begin
                    state_d = PS_COUNT;
                    cnt_d   = cnt_q + CNT_W'(1);
                end else begin
                    cnt_d   = '0;
                end
            end
            PS_COUNT: begin
                if (blk_en) begin
                    cnt_d   = cnt_q + CNT_W'(1);
                end else begin
                    state_d = PS_HOLD;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = PS_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs: tap k fires when the low k counter bits are all ones.
    always_comb begin
        tap_tick[0] = blk_en;
    end

    for (genvar k = 1; k < TAP_COUNT; k++) begin : g_tap
        always_comb begin
            tap_tick[k] = blk_en & (&cnt_q[k-1:0]);
        end
    end

endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div
    import pwm_rate_pkg::*;
#(
    parameter int TAP_COUNT = 11,
    parameter int SEL_W     = 4,
    parameter int RATIO_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 blk_en,
    input  logic [TAP_COUNT-1:0] tap_tick,
    input  logic [SEL_W-1:0]     src_sel,
    input  logic [RATIO_W-1:0]   ratio,
    output logic                 rate_tick
);

    localparam int               PAD_W    = 2 ** SEL_W;
    localparam logic [SEL_W-1:0] LAST_TAP = SEL_W'(TAP_COUNT - 1);

    div_state_e          state_q, state_d;
    logic [RATIO_W-1:0]  cnt_q, cnt_d;
    logic [SEL_W-1:0]    src_q;
    logic [RATIO_W-1:0]  ratio_q;

    logic [PAD_W-1:0]    tap_pad;
    logic                cfg_ok;
    logic                cfg_same;
    logic                src_hit;
    logic                at_end;

    always_comb begin
        tap_pad  = PAD_W'(tap_tick);
        cfg_ok   = blk_en && (ratio != '0) && (src_sel <= LAST_TAP);
        cfg_same = (src_sel == src_q) && (ratio == ratio_q);
        src_hit  = tap_pad[src_sel];
        at_end   = (cnt_q == (ratio - RATIO_W'(1)));
    end

    // Next state and count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DIV_OFF: begin
                cnt_d = '0;
                if (cfg_ok) begin
                    state_d = DIV_RUN;
                end
            end
            DIV_RUN: begin
                if (!cfg_ok) begin
                    state_d = DIV_OFF;
                    cnt_d   = '0;
                end else if (!cfg_same) begin
                    cnt_d   = '0;
                end else if (src_hit) begin
                    cnt_d   = at_end ? '0 : cnt_q + RATIO_W'(1);
                end
            end
            default: begin
                state_d = DIV_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIV_OFF;
            cnt_q   <= '0;
            src_q   <= '0;
            ratio_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            src_q   <= src_sel;
            ratio_q <= ratio;
        end
    end

    // Output.
    always_comb begin
        rate_tick = (state_q == DIV_RUN) && cfg_ok && cfg_same && src_hit && at_end;
    end

endmodule

// File: rtl/pwm_chan_sel.sv
module pwm_chan_sel #(
    parameter int TAP_COUNT = 11,
    parameter int SEL_W     = 4,
    parameter int NUM_CH    = 4
) (
    input  logic [TAP_COUNT-1:0]    tap_tick,
    input  logic                    rate_a_tick,
    input  logic                    rate_b_tick,
    input  logic [NUM_CH*SEL_W-1:0] ch_sel,
    output logic [NUM_CH-1:0]       ch_tick
);

    localparam int PAD_W = 2 ** SEL_W;

    logic [PAD_W-1:0] rate_vec;

    // Order: taps, then A, then B, then constant low.
    always_comb begin
        rate_vec = PAD_W'({rate_b_tick, rate_a_tick, tap_tick});
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            ch_tick[c] = rate_vec[ch_sel[c*SEL_W +: SEL_W]];
        end
    end

endmodule

// File: rtl/pwm_rate_gen.sv
module pwm_rate_gen #(
    parameter int TAP_COUNT = 11,
    parameter int SEL_W     = 4,
    parameter int RATIO_W   = 8,
    parameter int NUM_CH    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    blk_en,
    input  logic [SEL_W-1:0]        div_a_src,
    input  logic [RATIO_W-1:0]      div_a_ratio,
    input  logic [SEL_W-1:0]        div_b_src,
    input  logic [RATIO_W-1:0]      div_b_ratio,
    input  logic [NUM_CH*SEL_W-1:0] ch_sel,
    output logic [TAP_COUNT-1:0]    tap_tick,
    output logic                    rate_a_tick,
    output logic                    rate_b_tick,
    output logic [NUM_CH-1:0]       ch_tick
);

    pwm_tap_prescaler #(
        .TAP_COUNT (TAP_COUNT)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_en   (blk_en),
        .tap_tick (tap_tick)
    );

    pwm_lin_div #(
        .TAP_COUNT (TAP_COUNT),
        .SEL_W     (SEL_W),
        .RATIO_W   (RATIO_W)
    ) u_div_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_en    (blk_en),
        .tap_tick  (tap_tick),
        .src_sel   (div_a_src),
        .ratio     (div_a_ratio),
        .rate_tick (rate_a_tick)
    );

    pwm_lin_div #(
        .TAP_COUNT (TAP_COUNT),
        .SEL_W     (SEL_W),
        .RATIO_W   (RATIO_W)
    ) u_div_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_en    (blk_en),
        .tap_tick  (tap_tick),
        .src_sel   (div_b_src),
        .ratio     (div_b_ratio),
        .rate_tick (rate_b_tick)
    );

    pwm_chan_sel #(
        .TAP_COUNT (TAP_COUNT),
        .SEL_W     (SEL_W),
        .NUM_CH    (NUM_CH)
    ) u_sel (
        .tap_tick    (tap_tick),
        .rate_a_tick (rate_a_tick),
        .rate_b_tick (rate_b_tick),
        .ch_sel      (ch_sel),
        .ch_tick     (ch_tick)
    );

endmodule

// File: rtl/pwm_rate_chk.sv
module pwm_rate_chk #(
    parameter int TAP_COUNT = 11,
    parameter int SEL_W     = 4,
    parameter int RATIO_W   = 8,
    parameter int NUM_CH    = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    blk_en,
    input logic [SEL_W-1:0]        div_a_src,
    input logic [RATIO_W-1:0]      div_a_ratio,
    input logic [SEL_W-1:0]        div_b_src,
    input logic [RATIO_W-1:0]      div_b_ratio,
    input logic [NUM_CH*SEL_W-1:0] ch_sel,
    input logic [TAP_COUNT-1:0]    tap_tick,
    input logic                    rate_a_tick,
    input logic                    rate_b_tick,
    input logic [NUM_CH-1:0]       ch_tick
);

    localparam int               PAD_W    = 2 ** SEL_W;
    localparam logic [SEL_W-1:0] LAST_TAP = SEL_W'(TAP_COUNT - 1);
    localparam logic [SEL_W-1:0] SEL_A    = SEL_W'(TAP_COUNT);
    localparam logic [SEL_W-1:0] SEL_B    = SEL_W'(TAP_COUNT + 1);

    logic [PAD_W-1:0] tap_pad;
    always_comb tap_pad = PAD_W'(tap_tick);

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |-> (tap_tick == '0 && !rate_a_tick && !rate_b_tick && ch_tick == '0));

    assert_base_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        blk_en |-> tap_tick[0]);

    assert_tap_alt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tick[1] |=> !tap_tick[1]);

    for (genvar k = 1; k < TAP_COUNT; k++) begin : g_nest
        assert_tap_nest_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tap_tick[k] |-> tap_tick[k-1]);
    end

    assert_a_on_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rate_a_tick |-> tap_pad[div_a_src]);
    assert_b_on_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rate_b_tick |-> tap_pad[div_b_src]);

    assert_a_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_a_ratio == '0) |-> !rate_a_tick);
    assert_b_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_b_ratio == '0) |-> !rate_b_tick);

    assert_a_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_a_src > LAST_TAP) |-> !rate_a_tick);
    assert_b_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_b_src > LAST_TAP) |-> !rate_b_tick);

    assert_a_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_a_src != $past(div_a_src) || div_a_ratio != $past(div_a_ratio)) |-> !rate_a_tick);
    assert_b_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_b_src != $past(div_b_src) || div_b_ratio != $past(div_b_ratio)) |-> !rate_b_tick);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk_ch
        assert_ch_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[c*SEL_W +: SEL_W] <= LAST_TAP) |-> (ch_tick[c] == tap_pad[ch_sel[c*SEL_W +: SEL_W]]));
        assert_ch_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[c*SEL_W +: SEL_W] == SEL_A) |-> (ch_tick[c] == rate_a_tick));
        assert_ch_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[c*SEL_W +: SEL_W] == SEL_B) |-> (ch_tick[c] == rate_b_tick));
        assert_ch_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[c*SEL_W +: SEL_W] > SEL_B) |-> !ch_tick[c]);
    end

endmodule

bind pwm_rate_gen pwm_rate_chk #(
    .TAP_COUNT (TAP_COUNT),
    .SEL_W     (SEL_W),
    .RATIO_W   (RATIO_W),
    .NUM_CH    (NUM_CH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_en      (blk_en),
    .div_a_src   (div_a_src),
    .div_a_ratio (div_a_ratio),
    .div_b_src   (div_b_src),
    .div_b_ratio (div_b_ratio),
    .ch_sel      (ch_sel),
    .tap_tick    (tap_tick),
    .rate_a_tick (rate_a_tick),
    .rate_b_tick (rate_b_tick),
    .ch_tick     (ch_tick)
);

// File: tb/sim_pwm_rate_gen.sv
module sim_pwm_rate_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_en = 1'b0;
    logic [3:0]  div_a_src = '0;
    logic [7:0]  div_a_ratio = '0;
    logic [3:0]  div_b_src = '0;
    logic [7:0]  div_b_ratio = '0;
    logic [15:0] ch_sel = '0;
    logic [10:0] tap_tick;
    logic        rate_a_tick;
    logic        rate_b_tick;
    logic [3:0]  ch_tick;

    always #10 clk = ~clk;

    pwm_rate_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_en      (blk_en),
        .div_a_src   (div_a_src),
        .div_a_ratio (div_a_ratio),
        .div_b_src   (div_b_src),
        .div_b_ratio (div_b_ratio),
        .ch_sel      (ch_sel),
        .tap_tick    (tap_tick),
        .rate_a_tick (rate_a_tick),
        .rate_b_tick (rate_b_tick),
        .ch_tick     (ch_tick)
    );

    typedef struct packed {
        logic [10:0] taps;
        logic        a;
        logic        b;
        logic [3:0]  ch;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // Requirement-level reference state.
    int          mi = 0;
    bit          a_run = 1'b0, b_run = 1'b0;
    int          a_cnt = 0, b_cnt = 0;
    logic [3:0]  a_ls = '0, b_ls = '0;
    logic [7:0]  a_lr = '0, b_lr = '0;

    // Observed outputs of the last step.
    logic [10:0] obs_taps;
    logic        obs_a, obs_b;
    logic [3:0]  obs_ch;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [10:0] taps_of(input int i, input logic en);
        logic [10:0] t;
        for (int k = 0; k < 11; k++) begin
            t[k] = en && ((i % (1 << k)) == ((1 << k) - 1));
        end
        return t;
    endfunction

    task automatic div_ref(input logic en, input logic [10:0] t, input logic [3:0] src,
                           input logic [7:0] rat, inout bit run, inout int cnt,
                           inout logic [3:0] ls, inout logic [7:0] lr, output logic p);
        bit valid, same, hit;
        valid = en && (rat != 0) && (src <= 4'd10);
        same  = (src == ls) && (rat == lr);
        hit   = valid ? t[src] : 1'b0;
        p     = run && valid && same && hit && (cnt == int'(rat) - 1);
        if (!valid) begin
            run = 1'b0;
            cnt = 0;
        end else begin
            if (!run || !same) cnt = 0;
            else if (hit) cnt = p ? 0 : cnt + 1;
            run = 1'b1;
        end
        ls = src;
        lr = rat;
    endtask

    function automatic logic pick(input logic [3:0] s, input logic [10:0] t,
                                  input logic a, input logic b);
        if (s <= 4'd10) return t[s];
        if (s == 4'd11) return a;
        if (s == 4'd12) return b;
        return 1'b0;
    endfunction

    // Driver: predict this cycle, queue it, advance the reference.
    task automatic step();
        exp_t e;
        logic pa, pb;
        @(negedge clk);
        #1;
        e.taps = taps_of(mi, blk_en);
        div_ref(blk_en, e.taps, div_a_src, div_a_ratio, a_run, a_cnt, a_ls, a_lr, pa);
        div_ref(blk_en, e.taps, div_b_src, div_b_ratio, b_run, b_cnt, b_ls, b_lr, pb);
        e.a = pa;
        e.b = pb;
        for (int c = 0; c < 4; c++) begin
            e.ch[c] = pick(ch_sel[c*4 +: 4], e.taps, pa, pb);
        end
        exp_q.push_back(e);
        mi = blk_en ? mi + 1 : 0;
        obs_taps = tap_tick;
        obs_a    = rate_a_tick;
        obs_b    = rate_b_tick;
        obs_ch   = ch_tick;
        @(posedge clk);
        #2;
    endtask

    // Monitor: pop and compare every cycle.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(tap_tick == e.taps, "R1 R2 taps", int'(tap_tick), int'(e.taps));
                chk(rate_a_tick == e.a, "R3 R6 R7 rate_a", int'(rate_a_tick), int'(e.a));
                chk(rate_b_tick == e.b, "R3 R6 R7 rate_b", int'(rate_b_tick), int'(e.b));
                chk(ch_tick == e.ch, "R8 ch_tick", int'(ch_tick), int'(e.ch));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n_t0, n_t10, n_a, n_b, n_c3;

        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R1: released, still disabled
        step();
        chk(obs_taps == '0 && !obs_a && !obs_b && obs_ch == '0, "R1 reset idle",
            int'(obs_taps), 0);

        // R2 R3 R7 R8: long enabled run
        blk_en      = 1'b1;
        div_a_src   = 4'd0;  div_a_ratio = 8'd3;
        div_b_src   = 4'd2;  div_b_ratio = 8'd5;
        ch_sel      = {4'd10, 4'd12, 4'd11, 4'd0};
        n_t0 = 0; n_t10 = 0; n_a = 0; n_b = 0;
        for (int i = 0; i < 2100; i++) begin
            step();
            n_t0  += int'(obs_taps[0]);
            n_t10 += int'(obs_taps[10]);
            n_a   += int'(obs_a);
            n_b   += int'(obs_b);
        end
        chk(n_t0 == 2100, "R2 tap0 count", n_t0, 2100);
        chk(n_t10 == 2, "R2 tap10 count", n_t10, 2);
        chk(n_a == 699, "R3 rate_a count", n_a, 699);
        chk(n_b == 105, "R7 rate_b count", n_b, 105);

        // R4 R5 R8: divider off, reserved source, reserved channel select
        div_a_ratio = 8'd0;
        div_b_src   = 4'd13;
        ch_sel      = {4'd13, 4'd12, 4'd11, 4'd0};
        n_a = 0; n_b = 0; n_c3 = 0;
        for (int i = 0; i < 200; i++) begin
            step();
            n_a  += int'(obs_a);
            n_b  += int'(obs_b);
            n_c3 += int'(obs_ch[3]);
        end
        chk(n_a == 0, "R4 ratio zero", n_a, 0);
        chk(n_b == 0, "R5 reserved source", n_b, 0);
        chk(n_c3 == 0, "R8 reserved channel select", n_c3, 0);

        // R1: disable for one cycle
        blk_en = 1'b0;
        div_a_src = 4'd0; div_a_ratio = 8'd2;
        div_b_src = 4'd1; div_b_ratio = 8'd1;
        step();
        chk(obs_taps == '0 && !obs_a && !obs_b, "R1 disabled", int'(obs_taps), 0);

        // R6: restart after a ratio change
        blk_en = 1'b1;
        for (int i = 0; i < 10; i++) step();
        div_a_ratio = 8'd3;
        step();
        chk(obs_a == 1'b0, "R6 change cycle silent", int'(obs_a), 0);
        step();
        chk(obs_a == 1'b0, "R6 tick one after change", int'(obs_a), 0);
        step();
        chk(obs_a == 1'b0, "R6 tick two after change", int'(obs_a), 0);
        step();
        chk(obs_a == 1'b1, "R6 first pulse on third tick", int'(obs_a), 1);

        // R7: B unaffected while A source changes
        n_b = 0;
        div_a_src = 4'd3;
        for (int i = 0; i < 40; i++) begin
            step();
            n_b += int'(obs_b);
        end
        chk(n_b == 20, "R7 rate_b steady", n_b, 20);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule